// File: doc/BRIEF.md
# Four-Beat Burst Dual-Port SRAM Core

This block is a synthesizable model of a quad-data-rate static RAM. It has a separate write path and a separate read path, and every access moves a fixed burst of four 36-bit words. The two edges of the external main clock appear here as alternating phases of one internal beat clock `clk`. Every `clk` edge is one beat. The phase whose edge stands for the main clock's rising edge is called the rise phase, and the `rise_phase` output is high during the cycle before such an edge. Requests are active low and are sampled only on rise-phase edges. The burst address comes from the low two bits of the word address, which count up and wrap inside the aligned group of four.

A controller issues a write by pulling `wr_req_n` low with an address on a rise edge, then presents four data words on the following beats. Each word carries its own four active-low lane enables. A read issued the same way returns four words, each flagged by `rvalid`, starting one and a half main-clock cycles after the request edge. A request is honoured only if the same request line was high on the previous rise edge. This rule limits each port to one burst every two main-clock cycles. The read and write ports can be used on the same edge.

Top module: `qb4_sram`

## Requirements
- R1: Requests are sampled only on rise-phase edges, which are the `clk` edges that close a cycle with `rise_phase`=1. A low request during a cycle with `rise_phase`=0 has no effect.
- R2: A write accepted on rise edge E stores its words on edges E+2, E+3, E+4 and E+5. These are burst words 0..3 at addresses {A[7:2], A[1:0]+i mod 4}.
- R3: A read accepted on rise edge E drives burst words 0..3 after edges E+3, E+4, E+5 and E+6. It uses the same wrapping address order, and `rvalid` is high for exactly those beats.
- R4: A request is accepted only when its line was high on the previous rise edge. Otherwise the request is ignored, and so a request held low over consecutive rise edges starts only one burst.
- R5: The word is split into four 9-bit lanes. Lane k covers bits 9k+8..9k and is written only when `lane_wr_n[k]`=0. The lane enables are sampled separately on every write beat.
- R6: From reset until the first read beat, and between bursts, `rvalid`=0 and `rdata`=0.
- R7: A read and a write can both be accepted on the same rise edge, and both bursts then run to completion.
- R8: A read beat returns the stored word as it stood before that edge. A write to the same word on the same edge is not forwarded.
- R9: Synchronous active-high `rst` cancels pending and running bursts and clears the request history. Words already stored are kept.
- R10: `wdata` and `lane_wr_n` have no effect on beats that are not write beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; each edge is one phase of the main clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_n | input | 1 | Active-low read request |
| wr_req_n | input | 1 | Active-low write request |
| addr | input | ADDR_W | Word address of the burst |
| wdata | input | LANES*LANE_W | Write data word for the current beat |
| lane_wr_n | input | LANES | Active-low per-lane write enables for the current beat |
| rdata | output | LANES*LANE_W | Read data word, zero when idle |
| rvalid | output | 1 | High when `rdata` carries a burst word |
| rise_phase | output | 1 | High when the next `clk` edge is a rise-phase edge |

## Verification
The bench counts beats from reset release and keeps its own schedule indexed by beat. An accepted write puts its four stores at request edge +2 to +5. An accepted read puts its four outputs at request edge +3 to +6. For every beat the bench predicts `rvalid` and `rdata` from its model memory before applying any write due on that same edge. It compares these values, together with `rise_phase`, at the falling edge that follows. Seeded random traffic confined to 32 words mixes with directed cases for wrapped bursts, held requests, off-phase requests, same-edge read and write, a read overlapping a write burst, and reset in the middle of a burst.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
  localparam int BURST_LEN = 4;
  localparam int IDX_W     = 2;
  typedef logic [IDX_W-1:0] beat_idx_t;
  localparam beat_idx_t LAST_IDX = beat_idx_t'(BURST_LEN - 1);
endpackage

// File: rtl/qb4_req_gate.sv
module qb4_req_gate (
  input  logic clk,
  input  logic rst,
  input  logic k_edge,
  input  logic req_n,
  output logic acc_o
);
  logic prev_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_hi <= 1'b1;
    end else if (k_edge) begin
      prev_hi <= req_n;
    end
  end

  assign acc_o = k_edge && !req_n && prev_hi;

  // the rise edge after an acceptance never accepts again
  assert_gate_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    acc_o |=> ##1 !acc_o);
endmodule

// File: rtl/qb4_wr_seq.sv
module qb4_wr_seq
  import qb4_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              k_edge,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o
);
  logic              pend_v;
  logic [ADDR_W-1:0] pend_a;
  logic              act_v;
  logic [ADDR_W-1:0] act_a;
  beat_idx_t         act_idx;
  logic [ADDR_W-1:0] base;
  beat_idx_t         idx;
  logic              first;

  assign first = k_edge && pend_v;

  always_comb begin
    we_o = 1'b0;
    base = act_a;
    idx  = act_idx;
    if (first) begin
      we_o = 1'b1;
      base = pend_a;
      idx  = '0;
    end else if (act_v) begin
      we_o = 1'b1;
    end
  end

  assign waddr_o = {base[ADDR_W-1:IDX_W], base[IDX_W-1:0] + idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v  <= 1'b0;
      pend_a  <= '0;
      act_v   <= 1'b0;
      act_a   <= '0;
      act_idx <= '0;
    end else begin
      if (first) begin
        act_v   <= 1'b1;
        act_a   <= pend_a;
        act_idx <= beat_idx_t'(1);
        pend_v  <= 1'b0;
      end else if (act_v) begin
        act_idx <= act_idx + beat_idx_t'(1);
        if (act_idx == LAST_IDX) act_v <= 1'b0;
      end
      if (start) begin
        pend_v <= 1'b1;
        pend_a <= start_addr;
      end
    end
  end

  // a completed write burst was four consecutive store beats
  assert_wr_four_beats_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(act_v) |-> ($past(we_o, 1) && $past(we_o, 4)));
endmodule

// File: rtl/qb4_rd_seq.sv
module qb4_rd_seq
  import qb4_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              k_edge,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              re_o,
  output logic [ADDR_W-1:0] raddr_o
);
  logic              pend_v;
  logic [ADDR_W-1:0] pend_a;
  logic              act_v;
  logic [ADDR_W-1:0] act_a;
  beat_idx_t         act_idx;

  assign re_o    = act_v;
  assign raddr_o = {act_a[ADDR_W-1:IDX_W], act_a[IDX_W-1:0] + act_idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v  <= 1'b0;
      pend_a  <= '0;
      act_v   <= 1'b0;
      act_a   <= '0;
      act_idx <= '0;
    end else begin
      if (act_v) begin
        act_idx <= act_idx + beat_idx_t'(1);
        if (act_idx == LAST_IDX) act_v <= 1'b0;
      end
      if (k_edge && pend_v) begin
        act_v   <= 1'b1;
        act_a   <= pend_a;
        act_idx <= '0;
        pend_v  <= 1'b0;
      end
      if (start) begin
        pend_v <= 1'b1;
        pend_a <= start_addr;
      end
    end
  end

  // the request gate never hands over a read while one is still pending
  assert_rd_no_overrun_R4: assert property (@(posedge clk) disable iff (rst)
    start |-> !pend_v);
endmodule

// File: rtl/qb4_lane_ram.sv
module qb4_lane_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wd,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[raddr];
    else         q <= '0;
  end
endmodule

// File: rtl/qb4_sram.sv
module qb4_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_req_n,
  input  logic                    wr_req_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        lane_wr_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid,
  output logic                    rise_phase
);
  localparam int WORD_W = LANES * LANE_W;

  logic              k_ph;
  logic              rd_acc, wr_acc;
  logic              wr_we, rd_re, wr_go;
  logic [ADDR_W-1:0] waddr, raddr;

  always_ff @(posedge clk) begin
    if (rst) k_ph <= 1'b1;
    else     k_ph <= ~k_ph;
  end
  assign rise_phase = k_ph;

  qb4_req_gate u_rd_gate (
    .clk(clk), .rst(rst), .k_edge(k_ph), .req_n(rd_req_n), .acc_o(rd_acc));
  qb4_req_gate u_wr_gate (
    .clk(clk), .rst(rst), .k_edge(k_ph), .req_n(wr_req_n), .acc_o(wr_acc));

  qb4_wr_seq #(.ADDR_W(ADDR_W)) u_wr_seq (
    .clk(clk), .rst(rst), .k_edge(k_ph), .start(wr_acc), .start_addr(addr),
    .we_o(wr_we), .waddr_o(waddr));
  qb4_rd_seq #(.ADDR_W(ADDR_W)) u_rd_seq (
    .clk(clk), .rst(rst), .k_edge(k_ph), .start(rd_acc), .start_addr(addr),
    .re_o(rd_re), .raddr_o(raddr));

  // reset cancels any store still scheduled on the reset edge
  assign wr_go = wr_we && !rst;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    qb4_lane_ram #(.ADDR_W(ADDR_W), .DATA_W(LANE_W)) u_ram (
      .clk(clk), .rst(rst),
      .we(wr_go && !lane_wr_n[g]), .waddr(waddr), .wd(wdata[g*LANE_W +: LANE_W]),
      .re(rd_re), .raddr(raddr), .q(rdata[g*LANE_W +: LANE_W]));
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= rd_re;
  end

  assert_acc_on_rise_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_acc || wr_acc) |-> rise_phase);
  assert_rvalid_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) |-> rise_phase);
  assert_rvalid_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(rvalid) |-> $past(rvalid, 4));
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == {WORD_W{1'b0}}));
  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rvalid);
endmodule

// File: tb/qb4_sram_tb.sv
module qb4_sram_tb_top;
  localparam int CLK_P = 10;
  localparam int AW    = 8;
  localparam int NL    = 4;
  localparam int LW    = 9;
  localparam int WW    = NL * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_req_n = 1'b1;
  logic          wr_req_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wdata = '0;
  logic [NL-1:0] lane_wr_n = '1;
  logic [WW-1:0] rdata;
  logic          rvalid;
  logic          rise_phase;

  qb4_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
    .clk(clk), .rst(rst), .rd_req_n(rd_req_n), .wr_req_n(wr_req_n),
    .addr(addr), .wdata(wdata), .lane_wr_n(lane_wr_n),
    .rdata(rdata), .rvalid(rvalid), .rise_phase(rise_phase));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  string tag = "R6";

  logic [WW-1:0] m [256];
  int        e;
  bit        prh, pwh;
  bit        rv [16];
  bit        wv [16];
  logic [AW-1:0] ra [16];
  logic [AW-1:0] wa [16];

  task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] burst_addr(input logic [AW-1:0] b, input int i);
    logic [1:0] lo;
    lo = b[1:0] + 2'(i);
    return {b[AW-1:2], lo};
  endfunction

  task automatic model_reset();
    e = 0; prh = 1; pwh = 1;
    for (int i = 0; i < 16; i++) begin rv[i] = 0; wv[i] = 0; end
  endtask

  function automatic logic [WW-1:0] rnd_word();
    return {$urandom, $urandom} & {WW{1'b1}};
  endfunction

  // one beat: drive inputs, predict the edge, then check after it
  task automatic beat(input logic r_n, input logic w_n, input logic [AW-1:0] a,
                      input logic [WW-1:0] d, input logic [NL-1:0] ln);
    int s;
    logic          exp_v;
    logic [WW-1:0] exp_d;
    rd_req_n = r_n; wr_req_n = w_n; addr = a; wdata = d; lane_wr_n = ln;
    s = e % 16;
    exp_v = rv[s];
    exp_d = rv[s] ? m[ra[s]] : '0;
    rv[s] = 0;
    if (wv[s]) begin
      for (int k = 0; k < NL; k++)
        if (!ln[k]) m[wa[s]][k*LW +: LW] = d[k*LW +: LW];
      wv[s] = 0;
    end
    if (e % 2 == 0) begin
      if (!r_n && prh)
        for (int i = 0; i < 4; i++) begin
          rv[(e+3+i)%16] = 1; ra[(e+3+i)%16] = burst_addr(a, i);
        end
      if (!w_n && pwh)
        for (int i = 0; i < 4; i++) begin
          wv[(e+2+i)%16] = 1; wa[(e+2+i)%16] = burst_addr(a, i);
        end
      prh = r_n; pwh = w_n;
    end
    @(posedge clk);
    @(negedge clk);
    e++;
    chk(tag, 64'(rvalid), 64'(exp_v));
    chk(tag, 64'(rdata), 64'(exp_d));
    chk("R1", 64'(rise_phase), 64'(e % 2 == 0));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(1, 1, 8'($urandom), rnd_word(), 4'($urandom));
  endtask

  task automatic align();
    if (e % 2 != 0) idle(1);
  endtask

  task automatic wr_burst(input logic [AW-1:0] a, input logic [NL-1:0] l0,
                          input logic [NL-1:0] l1, input logic [NL-1:0] l2,
                          input logic [NL-1:0] l3);
    align();
    beat(1, 0, a, rnd_word(), 4'($urandom));
    idle(1);
    beat(1, 1, 0, rnd_word(), l0);
    beat(1, 1, 0, rnd_word(), l1);
    beat(1, 1, 0, rnd_word(), l2);
    beat(1, 1, 0, rnd_word(), l3);
  endtask

  task automatic rd_burst(input logic [AW-1:0] a);
    align();
    beat(0, 1, a, rnd_word(), 4'($urandom));
    idle(7);
  endtask

  task automatic do_reset();
    rd_req_n = 1; wr_req_n = 1;
    rst = 1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R9", 64'(rvalid), 64'd0);
    chk("R9", 64'(rdata), 64'd0);
    rst = 0;
    model_reset();
  endtask

  initial begin
    void'($urandom(32'h51a7));
    repeat (3) @(negedge clk);
    chk("R6", 64'(rvalid), 64'd0);
    chk("R6", 64'(rdata), 64'd0);
    chk("R6", 64'(rise_phase), 64'd1);
    rst = 0;
    model_reset();

    tag = "R2";
    for (int k = 0; k < 8; k++) wr_burst(8'(k*4), 4'h0, 4'h0, 4'h0, 4'h0);
    tag = "R3";
    rd_burst(8'd0);
    tag = "R2";
    wr_burst(8'd10, 4'h0, 4'h0, 4'h0, 4'h0);
    rd_burst(8'd10);
    tag = "R5";
    wr_burst(8'd16, 4'he, 4'hd, 4'h3, 4'hf);
    rd_burst(8'd16);
    tag = "R4";
    align();
    beat(0, 0, 8'd4, rnd_word(), 4'h0);
    idle(1);
    beat(0, 0, 8'd12, rnd_word(), 4'h0);
    idle(1);
    beat(0, 0, 8'd20, rnd_word(), 4'h0);
    beat(1, 1, 8'd0, rnd_word(), 4'h0);
    idle(8);
    rd_burst(8'd12);
    tag = "R1";
    align();
    idle(1);
    beat(0, 0, 8'd24, rnd_word(), 4'h0);
    idle(8);
    rd_burst(8'd24);
    tag = "R7";
    align();
    beat(0, 0, 8'd8, rnd_word(), 4'h0);
    idle(8);
    tag = "R8";
    align();
    beat(0, 1, 8'd8, rnd_word(), 4'h0);
    idle(1);
    beat(1, 0, 8'd9, rnd_word(), 4'h0);
    idle(9);
    tag = "R10";
    idle(12);
    rd_burst(8'd28);
    tag = "R9";
    align();
    beat(1, 0, 8'd20, rnd_word(), 4'h0);
    idle(1);
    beat(1, 1, 8'd0, rnd_word(), 4'h0);
    do_reset();
    rd_burst(8'd20);
    tag = "R3";
    for (int i = 0; i < 3000; i++)
      beat(($urandom % 5) < 2 ? 1'b0 : 1'b1, ($urandom % 5) < 2 ? 1'b0 : 1'b1,
           8'($urandom % 32), rnd_word(), 4'($urandom));
    idle(8);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    nerr++;
    nchk++;
    $display("FAIL watchdog (all): actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule